// File: doc/BRIEF.md
# Processor Status Register with Guarded Power Flags

This block is the eight-bit condition and power status register of a small microcontroller core. Four arithmetic condition flags sit in the low nibble: carry, half carry, zero and signed overflow. The ALU updates each of them through its own enable. Software can also overwrite them with an ordinary data write to the register. Two power flags sit above them: a sleep flag that records entry into halt, and an expiry flag that records a watchdog time-out. Software writes cannot change either power flag. Only power-up and three single-cycle event pulses move them: clear-watchdog, halt and watchdog time-out. The two top bits are not implemented. The register is never saved on its own on interrupt entry or subroutine call, so the core's surrounding logic is responsible for saving it.

The power flags are held in a four-state machine whose state encoding is {expiry, sleep}. The states are `PT_AWAKE` (00), `PT_SLEPT` (01), `PT_EXPIRED` (10) and `PT_SLEPT_EXPIRED` (11). From every state, the next state is set by the halt, clear-watchdog and time-out pulses:
- The sleep bit becomes 1 on halt.
- Otherwise it becomes 0 on clear-watchdog.
- Otherwise it holds.
- The expiry bit becomes 1 on time-out.
- Otherwise it becomes 0 on clear-watchdog or halt.
- Otherwise it holds.

This gives the following transitions:
- `PT_AWAKE` goes to `PT_SLEPT` on halt, to `PT_EXPIRED` on time-out, and to `PT_SLEPT_EXPIRED` on both.
- `PT_SLEPT` and `PT_SLEPT_EXPIRED` return to `PT_AWAKE` on clear-watchdog alone.
- `PT_EXPIRED` returns to `PT_AWAKE` on clear-watchdog alone, and goes to `PT_SLEPT` on halt alone.
- Every state stays where it is when no pulse is present.

Top module: `cpu_status_reg`

## Requirements
- R1: A synchronous power-up reset (`pwr_rst` high at a clock edge) makes `stat_q` read 0x00 after that edge.
- R2: Bits 7 and 6 of `stat_q` always read 0, whatever value is written.
- R3: With `sw_we` high, bits 3..0 of `stat_q` take `sw_data[3:0]` after the edge (bit0 carry, bit1 half carry, bit2 zero, bit3 overflow). This overrides any ALU update in the same cycle.
- R4: With `sw_we` low, each flag n in bits 3..0 whose `alu_en[n]` is high takes `alu_flags[n]`. Flags whose enable is low keep their value.
- R5: A software write never changes bit 4 (sleep) or bit 5 (expiry).
- R6: A halt pulse with no time-out sets bit 4 and clears bit 5.
- R7: A clear-watchdog pulse alone clears both bit 4 and bit 5.
- R8: A time-out pulse alone sets bit 5 and leaves bit 4 unchanged.
- R9: A time-out that coincides with clear-watchdog or halt leaves bit 5 set.
- R10: When halt and clear-watchdog coincide, halt wins and bit 4 is set.
- R11: With no event pulse, bits 5 and 4 hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| pwr_rst | input | 1 | Synchronous power-up reset, active high |
| alu_flags | input | 4 | New condition flag values from the ALU |
| alu_en | input | 4 | Per-flag update enables from the ALU |
| sw_we | input | 1 | Software data write strobe for this register |
| sw_data | input | 8 | Software write byte |
| evt_clrwdt | input | 1 | Clear-watchdog instruction pulse |
| evt_halt | input | 1 | Halt instruction pulse |
| evt_wdt_to | input | 1 | Watchdog time-out pulse |
| stat_q | output | 8 | Register read value |

## Verification
The condition nibble is driven with all 256 pairs of enable mask and flag value in sequence. This shows that each flag updates only under its own enable, and catches a swapped or shared enable. A sweep of all 256 write bytes, each paired with a full and opposing ALU update, checks write priority, the masked top bits and the immunity of the power flags. All eight combinations of event pulses are applied from each of the four power states, which separates the halt-over-clear rule, the time-out-over-clear rule and plain holding.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;
    parameter int STAT_W  = 8;
    parameter int COND_W  = 4;
    parameter int POS_SLP = 4;
    parameter int POS_EXP = 5;

    typedef enum logic [1:0] {
        PT_AWAKE         = 2'b00,
        PT_SLEPT         = 2'b01,
        PT_EXPIRED       = 2'b10,
        PT_SLEPT_EXPIRED = 2'b11
    } pt_state_e;
endpackage

// File: rtl/cond_flag_bank.sv
module cond_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] alu_flags,
    input  logic [W-1:0] alu_en,
    input  logic         sw_we,
    input  logic [W-1:0] sw_bits,
    output logic [W-1:0] flags_q
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        logic nxt;
        always_comb begin
            if (sw_we)          nxt = sw_bits[i];
            else if (alu_en[i]) nxt = alu_flags[i];
            else                nxt = flags_q[i];
        end
        always_ff @(posedge clk) begin
            if (rst) flags_q[i] <= 1'b0;
            else     flags_q[i] <= nxt;
        end
    end

    // R3: software write wins over the ALU
    p_sw_prio_r3: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> flags_q == $past(sw_bits))
        else $error("p_sw_prio_r3");

    // R4: disabled flags hold, enabled flags follow the ALU
    p_alu_upd_r4: assert property (@(posedge clk) disable iff (rst)
        !sw_we |=> flags_q == (($past(alu_flags) & $past(alu_en)) |
                               ($past(flags_q) & ~$past(alu_en))))
        else $error("p_alu_upd_r4");
endmodule

// File: rtl/power_flag_fsm.sv
module power_flag_fsm
    import cpu_status_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt_clrwdt,
    input  logic evt_halt,
    input  logic evt_wdt_to,
    output logic sleep_q,
    output logic expiry_q
);
    pt_state_e state, state_nxt;
    logic clr_any;

    assign clr_any = evt_clrwdt | evt_halt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            PT_AWAKE:
                state_nxt = pt_state_e'({evt_wdt_to, evt_halt});
            PT_SLEPT:
                state_nxt = pt_state_e'({evt_wdt_to, evt_halt | ~evt_clrwdt});
            PT_EXPIRED:
                state_nxt = pt_state_e'({evt_wdt_to | ~clr_any, evt_halt});
            PT_SLEPT_EXPIRED:
                state_nxt = pt_state_e'({evt_wdt_to | ~clr_any,
                                         evt_halt | ~evt_clrwdt});
            default:
                state_nxt = PT_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PT_AWAKE;
        else     state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            PT_AWAKE:         begin sleep_q = 1'b0; expiry_q = 1'b0; end
            PT_SLEPT:         begin sleep_q = 1'b1; expiry_q = 1'b0; end
            PT_EXPIRED:       begin sleep_q = 1'b0; expiry_q = 1'b1; end
            PT_SLEPT_EXPIRED: begin sleep_q = 1'b1; expiry_q = 1'b1; end
            default:          begin sleep_q = 1'b0; expiry_q = 1'b0; end
        endcase
    end

    p_halt_sets_sleep_r6: assert property (@(posedge clk) disable iff (rst)
        evt_halt |=> sleep_q)
        else $error("p_halt_sets_sleep_r6");

    p_clrwdt_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (evt_clrwdt && !evt_halt && !evt_wdt_to) |=> (!sleep_q && !expiry_q))
        else $error("p_clrwdt_clears_r7");

    p_timeout_keeps_sleep_r8: assert property (@(posedge clk) disable iff (rst)
        (evt_wdt_to && !clr_any) |=> (expiry_q && sleep_q == $past(sleep_q)))
        else $error("p_timeout_keeps_sleep_r8");

    p_timeout_wins_r9: assert property (@(posedge clk) disable iff (rst)
        evt_wdt_to |=> expiry_q)
        else $error("p_timeout_wins_r9");

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(evt_clrwdt || evt_halt || evt_wdt_to) |=> $stable({expiry_q, sleep_q}))
        else $error("p_idle_hold_r11");
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
    import cpu_status_pkg::*;
(
    input  logic              clk,
    input  logic              pwr_rst,
    input  logic [COND_W-1:0] alu_flags,
    input  logic [COND_W-1:0] alu_en,
    input  logic              sw_we,
    input  logic [STAT_W-1:0] sw_data,
    input  logic              evt_clrwdt,
    input  logic              evt_halt,
    input  logic              evt_wdt_to,
    output logic [STAT_W-1:0] stat_q
);
    localparam int PAD_W = STAT_W - COND_W - 2;

    logic [COND_W-1:0] cond_q;
    logic              sleep_q, expiry_q;

    cond_flag_bank #(.W(COND_W)) u_cond (
        .clk       (clk),
        .rst       (pwr_rst),
        .alu_flags (alu_flags),
        .alu_en    (alu_en),
        .sw_we     (sw_we),
        .sw_bits   (sw_data[COND_W-1:0]),
        .flags_q   (cond_q)
    );

    power_flag_fsm u_pwr (
        .clk        (clk),
        .rst        (pwr_rst),
        .evt_clrwdt (evt_clrwdt),
        .evt_halt   (evt_halt),
        .evt_wdt_to (evt_wdt_to),
        .sleep_q    (sleep_q),
        .expiry_q   (expiry_q)
    );

    assign stat_q = {{PAD_W{1'b0}}, expiry_q, sleep_q, cond_q};

    p_reset_clear_r1: assert property (@(posedge clk)
        pwr_rst |=> stat_q == '0)
        else $error("p_reset_clear_r1");

    p_write_no_power_r5: assert property (@(posedge clk) disable iff (pwr_rst)
        (sw_we && !evt_clrwdt && !evt_halt && !evt_wdt_to)
            |=> $stable(stat_q[POS_EXP:POS_SLP]))
        else $error("p_write_no_power_r5");

    // R10: coincident halt and clear-watchdog leave the sleep flag set
    p_halt_over_clr_r10: assert property (@(posedge clk) disable iff (pwr_rst)
        (evt_halt && evt_clrwdt) |=> stat_q[POS_SLP])
        else $error("p_halt_over_clr_r10");
endmodule

// File: tb/cpu_status_reg_test.sv
module cpu_status_reg_test;
    localparam time CLK_PER = 10ns;

    logic       clk = 1'b0;
    logic       pwr_rst = 1'b1;
    logic [3:0] alu_flags = '0, alu_en = '0;
    logic       sw_we = 1'b0;
    logic [7:0] sw_data = '0;
    logic       evt_clrwdt = 1'b0, evt_halt = 1'b0, evt_wdt_to = 1'b0;
    logic [7:0] stat_q;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    logic [3:0] m_cond = '0;
    logic       m_slp = 1'b0, m_exp = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    cpu_status_reg uut (
        .clk(clk), .pwr_rst(pwr_rst), .alu_flags(alu_flags), .alu_en(alu_en),
        .sw_we(sw_we), .sw_data(sw_data), .evt_clrwdt(evt_clrwdt),
        .evt_halt(evt_halt), .evt_wdt_to(evt_wdt_to), .stat_q(stat_q)
    );

    function automatic logic [7:0] model_val();
        return {2'b00, m_exp, m_slp, m_cond};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, update the model, sample at the next falling edge.
    task automatic cycle(input logic rst, input logic [3:0] af, input logic [3:0] ae,
                         input logic we, input logic [7:0] wd,
                         input logic clr, input logic hlt, input logic wto);
        pwr_rst = rst; alu_flags = af; alu_en = ae; sw_we = we; sw_data = wd;
        evt_clrwdt = clr; evt_halt = hlt; evt_wdt_to = wto;
        if (rst) begin
            m_cond = '0; m_slp = 0; m_exp = 0;
        end else begin
            if (we) m_cond = wd[3:0];
            else    m_cond = (af & ae) | (m_cond & ~ae);
            m_exp = wto ? 1'b1 : ((clr | hlt) ? 1'b0 : m_exp);
            m_slp = hlt ? 1'b1 : (clr ? 1'b0 : m_slp);
        end
        @(posedge clk);
        @(negedge clk);
        pwr_rst = 0; sw_we = 0; alu_en = '0;
        evt_clrwdt = 0; evt_halt = 0; evt_wdt_to = 0;
    endtask

    function automatic string evt_tag(input logic clr, input logic hlt, input logic wto);
        if (wto && (clr || hlt)) return "R9";
        if (hlt && clr)          return "R10";
        if (hlt)                 return "R6";
        if (clr)                 return "R7";
        if (wto)                 return "R8";
        return "R11";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cycle(1, '0, '0, 0, '0, 0, 0, 0);
        check("R1 reset", stat_q, 8'h00);

        // R4: every enable mask against every flag value
        for (int e = 0; e < 16; e++) begin
            for (int f = 0; f < 16; f++) begin
                cycle(0, 4'(f), 4'(e), 0, '0, 0, 0, 0);
                check("R4 alu update", stat_q, model_val());
            end
        end

        // Put both power flags high, then sweep every write byte
        cycle(0, '0, '0, 0, '0, 0, 1, 1);
        check("R9 halt+timeout", stat_q, model_val());
        for (int d = 0; d < 256; d++) begin
            cycle(0, ~d[3:0], 4'hF, 1, 8'(d), 0, 0, 0);
            check("R3 write priority", {4'h0, stat_q[3:0]}, {4'h0, 4'(d)});
            check("R5 power flags immune", {6'h0, stat_q[5:4]}, 8'h03);
            check("R2 top bits zero", {6'h0, stat_q[7:6]}, 8'h00);
        end

        // Every event combination from every power state
        for (int s = 0; s < 4; s++) begin
            for (int ev = 0; ev < 8; ev++) begin
                cycle(1, '0, '0, 0, '0, 0, 0, 0);
                cycle(0, '0, '0, 0, '0, 0, s[0], s[1]);
                check("R6 R8 preset", stat_q, {2'b00, s[1], s[0], 4'h0});
                cycle(0, '0, '0, 0, '0, ev[0], ev[1], ev[2]);
                check(evt_tag(ev[0], ev[1], ev[2]), stat_q, model_val());
            end
        end

        // Reset from a fully populated register
        cycle(0, 4'hF, 4'hF, 0, '0, 0, 1, 1);
        check("R4 R6 populate", stat_q, 8'h3F);
        cycle(1, 4'hF, 4'hF, 1, 8'hFF, 1, 1, 1);
        check("R1 reset overrides all", stat_q, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule